// File: doc/BRIEF.md
# Master-Slave PWM Timer Pair

Two coupled 16-bit down-counters generate a pulse-width-modulated output. The period channel loads a period value. It counts down once per enabled count clock and raises a one-clock tick each time it passes through zero, then reloads. The duty channel is a one-shot counter that this tick re-arms. It loads the duty value, drives the output to its active level from the next enabled count clock, and returns the output to idle when its count runs out. It then waits for the next tick. With period value P and duty value D, the output is active for min(D, P+1) of every P+1 enabled count clocks.

Software supplies a period value, a duty value, an output polarity and two output-control bits: output enable and a software output bit. It starts and stops both channels with single-cycle trigger pulses. Both counters and both running flags can be read at any time.

The period channel has two states. IDLE goes to RUN on a start trigger. RUN reloads on the zero count and goes back to IDLE on a stop trigger. The duty channel has four states. IDLE goes to DONE on a start trigger. Any state other than IDLE goes to ARMED on a tick. ARMED goes to ACTIVE on the next enabled clock when the loaded value is non-zero, and to DONE when it is zero. ACTIVE goes to DONE when the enabled clock takes its count from 1 to 0. A stop trigger sends any state to IDLE.

Top module: `pwm_pair_timer`

## Requirements
- R1: A start trigger (start_trig high, stop_trig low) sets master_run and slave_run in the next cycle. In that same cycle it raises master_irq and loads period_cnt with the period value.
- R2: While running, period_cnt decrements on each enabled count clock. When it is 0 on an enabled clock, it reloads the period value and master_irq is high for the following cycle. The tick therefore repeats every P+1 enabled count clocks.
- R3: In the cycle after each master_irq, duty_cnt holds the duty value. The output level goes active on the next enabled count clock and stays active for D enabled count clocks. When D is P+1 or more, the output stays active. When D is 0, the output never goes active.
- R4: Period and duty writes while running are stored at once. They are used only at the next period reload or duty load.
- R5: A polarity write is ignored while the channels are running.
- R6: A stop trigger clears both running flags in the next cycle. Both counters and the output level keep their values. A stop trigger wins over a start trigger in the same cycle.
- R7: With cnt_en low, neither counter advances and no new tick is produced.
- R8: With output enable at 1, pwm_pin equals the timer output level XOR polarity (polarity 1 means active-low). With output enable at 0, pwm_pin equals the software output bit.
- R9: A low rst_n at a clock edge clears both counters, both flags, master_irq, the output level, the stored values, output enable and the software output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count-clock enable |
| per_wr | input | 1 | Period value write strobe |
| per_wdata | input | 16 | Period value |
| duty_wr | input | 1 | Duty value write strobe |
| duty_wdata | input | 16 | Duty value |
| pol_wr | input | 1 | Polarity write strobe (locked while running) |
| pol_wdata | input | 1 | Polarity, 1 = active-low |
| ctl_wr | input | 1 | Output-control write strobe |
| oe_wdata | input | 1 | Output enable |
| obit_wdata | input | 1 | Software output bit |
| start_trig | input | 1 | Start both channels (single-cycle pulse) |
| stop_trig | input | 1 | Stop both channels (single-cycle pulse) |
| master_irq | output | 1 | Period tick pulse |
| period_cnt | output | 16 | Period counter value |
| duty_cnt | output | 16 | Duty counter value |
| master_run | output | 1 | Period channel running |
| slave_run | output | 1 | Duty channel running |
| pwm_pin | output | 1 | PWM output pin |

## Verification
A sweep covers period values 0 to 4 and every duty value from 0 to P+2. Each sample of the output, the tick and the period counter is compared against closed-form arithmetic. This separates ordinary duty, duty equal to P, saturated duty and zero duty. A second run changes the period and duty values mid-period, which tells deferred loading from immediate loading. A run with the count enable toggling shows that period and duty are counted in enabled clocks rather than raw clocks. A stop, polarity, output-control and reset sequence separates held state from cleared state.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    typedef enum logic {
        M_IDLE = 1'b0,
        M_RUN  = 1'b1
    } m_state_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARMED  = 2'd1,
        S_ACTIVE = 2'd2,
        S_DONE   = 2'd3
    } s_state_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             pol_wr,
    input  logic             pol_wdata,
    input  logic             ctl_wr,
    input  logic             oe_wdata,
    input  logic             obit_wdata,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] duty_q,
    output logic             pol_q,
    output logic             oe_q,
    output logic             obit_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
            pol_q    <= 1'b0;
            oe_q     <= 1'b0;
            obit_q   <= 1'b0;
        end else begin
            if (per_wr)  period_q <= per_wdata;
            if (duty_wr) duty_q   <= duty_wdata;
            // polarity only changes while both channels are halted
            if (pol_wr && !locked) pol_q <= pol_wdata;
            if (ctl_wr) begin
                oe_q   <= oe_wdata;
                obit_q <= obit_wdata;
            end
        end
    end
endmodule

// File: rtl/pwm_master_chan.sv
module pwm_master_chan
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] period_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             run
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    m_state_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tick_q, tick_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_IDLE;
            cnt_q   <= '0;
            tick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tick_q  <= tick_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tick_d  = 1'b0;
        unique case (state_q)
            M_IDLE: begin
                if (start && !stop) begin
                    state_d = M_RUN;
                    cnt_d   = period_val;
                    tick_d  = 1'b1;
                end
            end
            M_RUN: begin
                if (stop) begin
                    state_d = M_IDLE;
                end else if (start) begin
                    cnt_d  = period_val;
                    tick_d = 1'b1;
                end else if (cnt_en) begin
                    if (cnt_q == '0) begin
                        cnt_d  = period_val;
                        tick_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
        endcase
    end

    assign cnt  = cnt_q;
    assign tick = tick_q;
    assign run  = (state_q == M_RUN);
endmodule

// File: rtl/pwm_slave_chan.sv
module pwm_slave_chan
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start,
    input  logic             stop,
    input  logic             launch,
    input  logic [CNT_W-1:0] duty_val,
    output logic [CNT_W-1:0] cnt,
    output logic             level,
    output logic             run
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    s_state_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_q, lvl_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        if (stop) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) state_d = S_DONE;
                end
                S_ARMED: begin
                    if (cnt_en) begin
                        if (cnt_q == '0) begin
                            lvl_d   = 1'b0;
                            state_d = S_DONE;
                        end else begin
                            lvl_d   = 1'b1;
                            state_d = S_ACTIVE;
                        end
                    end
                end
                S_ACTIVE: begin
                    if (cnt_en) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q <= ONE) begin
                            cnt_d   = '0;
                            lvl_d   = 1'b0;
                            state_d = S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    state_d = S_DONE;
                end
            endcase
            // a period tick re-arms the one-shot from any live state
            if (launch && state_q != S_IDLE) begin
                cnt_d   = duty_val;
                state_d = S_ARMED;
            end
        end
    end

    assign cnt   = cnt_q;
    assign level = lvl_q;
    assign run   = (state_q != S_IDLE);
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             pol_wr,
    input  logic             pol_wdata,
    input  logic             ctl_wr,
    input  logic             oe_wdata,
    input  logic             obit_wdata,
    input  logic             start_trig,
    input  logic             stop_trig,
    output logic             master_irq,
    output logic [CNT_W-1:0] period_cnt,
    output logic [CNT_W-1:0] duty_cnt,
    output logic             master_run,
    output logic             slave_run,
    output logic             pwm_pin
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic             pol_q;
    logic             oe_q;
    logic             obit_q;
    logic             pwm_level;

    pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .locked     (master_run | slave_run),
        .per_wr     (per_wr),
        .per_wdata  (per_wdata),
        .duty_wr    (duty_wr),
        .duty_wdata (duty_wdata),
        .pol_wr     (pol_wr),
        .pol_wdata  (pol_wdata),
        .ctl_wr     (ctl_wr),
        .oe_wdata   (oe_wdata),
        .obit_wdata (obit_wdata),
        .period_q   (period_q),
        .duty_q     (duty_q),
        .pol_q      (pol_q),
        .oe_q       (oe_q),
        .obit_q     (obit_q)
    );

    pwm_master_chan #(.CNT_W(CNT_W)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .start      (start_trig),
        .stop       (stop_trig),
        .period_val (period_q),
        .cnt        (period_cnt),
        .tick       (master_irq),
        .run        (master_run)
    );

    pwm_slave_chan #(.CNT_W(CNT_W)) u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .start    (start_trig),
        .stop     (stop_trig),
        .launch   (master_irq),
        .duty_val (duty_q),
        .cnt      (duty_cnt),
        .level    (pwm_level),
        .run      (slave_run)
    );

    assign pwm_pin = oe_q ? (pwm_level ^ pol_q) : obit_q;
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             start_trig,
    input logic             stop_trig,
    input logic             master_irq,
    input logic [CNT_W-1:0] period_cnt,
    input logic [CNT_W-1:0] duty_cnt,
    input logic             master_run,
    input logic             slave_run,
    input logic [CNT_W-1:0] period_q,
    input logic [CNT_W-1:0] duty_q,
    input logic             pol_q,
    input logic             pwm_level
);
    // R1
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_trig && !stop_trig) |=> (master_run && slave_run && master_irq
                                        && period_cnt == $past(period_q)));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_run && cnt_en && !start_trig && !stop_trig && period_cnt == '0)
        |=> (master_irq && period_cnt == $past(period_q)));

    // R2
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_run && cnt_en && !start_trig && !stop_trig && period_cnt != '0)
        |=> (!master_irq && period_cnt == $past(period_cnt) - CNT_W'(1)));

    // R3
    duty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_irq && !stop_trig) |=> (duty_cnt == $past(duty_q)));

    // R5
    pol_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_run |=> $stable(pol_q));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_trig |=> (!master_run && !slave_run && $stable(period_cnt)
                       && $stable(duty_cnt) && $stable(pwm_level)));

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_run && !cnt_en && !start_trig && !stop_trig)
        |=> ($stable(period_cnt) && !master_irq));

    // R2
    tick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_irq |-> master_run);
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .start_trig (start_trig),
    .stop_trig  (stop_trig),
    .master_irq (master_irq),
    .period_cnt (period_cnt),
    .duty_cnt   (duty_cnt),
    .master_run (master_run),
    .slave_run  (slave_run),
    .period_q   (period_q),
    .duty_q     (duty_q),
    .pol_q      (pol_q),
    .pwm_level  (pwm_level)
);

// File: tb/pwm_pair_timer_bench.sv
`timescale 1ns/1ps
module pwm_pair_timer_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b1;
    logic         per_wr = 1'b0;
    logic [W-1:0] per_wdata = '0;
    logic         duty_wr = 1'b0;
    logic [W-1:0] duty_wdata = '0;
    logic         pol_wr = 1'b0;
    logic         pol_wdata = 1'b0;
    logic         ctl_wr = 1'b0;
    logic         oe_wdata = 1'b0;
    logic         obit_wdata = 1'b0;
    logic         start_trig = 1'b0;
    logic         stop_trig = 1'b0;
    logic         master_irq;
    logic [W-1:0] period_cnt;
    logic [W-1:0] duty_cnt;
    logic         master_run;
    logic         slave_run;
    logic         pwm_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_pair_timer #(.CNT_W(W)) u_pwm_pair_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .pol_wr(pol_wr), .pol_wdata(pol_wdata),
        .ctl_wr(ctl_wr), .oe_wdata(oe_wdata), .obit_wdata(obit_wdata),
        .start_trig(start_trig), .stop_trig(stop_trig),
        .master_irq(master_irq), .period_cnt(period_cnt), .duty_cnt(duty_cnt),
        .master_run(master_run), .slave_run(slave_run), .pwm_pin(pwm_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // inputs set before the call are taken at the next rising edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic setup(input int p, input int d);
        per_wr = 1'b1; per_wdata = W'(p);
        duty_wr = 1'b1; duty_wdata = W'(d);
        ctl_wr = 1'b1; oe_wdata = 1'b1; obit_wdata = 1'b0;
        step();
        per_wr = 1'b0; duty_wr = 1'b0; ctl_wr = 1'b0;
    endtask

    task automatic start_now();
        start_trig = 1'b1;
        step();
        start_trig = 1'b0;
    endtask

    function automatic bit exp_level(input int c, input int p, input int d);
        int dh;
        dh = (d > p + 1) ? p + 1 : d;
        return (c >= 2) && (((c - 2) % (p + 1)) < dh);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        bit held;
        int hi, ticks;
        logic [W-1:0] pc_hold, dc_hold;

        // R9 reset state
        do_reset();
        chk(!master_run && !slave_run && !master_irq, "R9 flags", int'(master_run), 0);
        chk(period_cnt == 0 && duty_cnt == 0, "R9 counters", int'(period_cnt), 0);
        chk(pwm_pin == 1'b0, "R9 pin", int'(pwm_pin), 0);

        // R1 R2 R3 sweep of period and duty
        for (int p = 0; p <= 4; p++) begin
            for (int d = 0; d <= p + 2; d++) begin
                do_reset();
                setup(p, d);
                start_now();
                for (int c = 0; c < 3 * (p + 1) + 4; c++) begin
                    if (c > 0) step();
                    if (c == 0) chk(master_run && slave_run, "R1 run flags", int'(master_run), 1);
                    if (c == 1) chk(duty_cnt == W'(d), "R3 duty load", int'(duty_cnt), d);
                    chk(master_irq == (c % (p + 1) == 0), "R2 tick", int'(master_irq),
                        int'(c % (p + 1) == 0));
                    chk(period_cnt == W'(p - c % (p + 1)), "R2 count", int'(period_cnt),
                        p - c % (p + 1));
                    chk(pwm_pin == exp_level(c, p, d), "R3 level", int'(pwm_pin),
                        int'(exp_level(c, p, d)));
                end
            end
        end

        // R4 writes while running take effect at the next load
        do_reset();
        setup(7, 2);
        start_now();
        for (int c = 0; c <= 24; c++) begin
            bit ti, lv;
            if (c > 0) step();
            if (c == 3) begin
                per_wr = 1'b0; duty_wr = 1'b0;
            end
            ti = (c == 0) || (c == 8) || (c >= 12 && c % 4 == 0);
            lv = (c == 2) || (c == 3) || (c >= 10);
            chk(master_irq == ti, "R4 tick", int'(master_irq), int'(ti));
            chk(pwm_pin == lv, "R4 level", int'(pwm_pin), int'(lv));
            if (c == 2) begin
                per_wr = 1'b1; per_wdata = W'(3);
                duty_wr = 1'b1; duty_wdata = W'(5);
            end
        end

        // R7 count enable gating
        do_reset();
        setup(3, 2);
        cnt_en = 1'b0;
        start_now();
        chk(master_irq && period_cnt == 3, "R7 start tick", int'(period_cnt), 3);
        for (int c = 1; c <= 4; c++) begin
            step();
            chk(period_cnt == 3 && !master_irq && !pwm_pin, "R7 hold", int'(period_cnt), 3);
        end
        hi = 0; ticks = 0;
        for (int c = 0; c < 40; c++) begin
            cnt_en = (c % 2 == 0);
            step();
            if (c >= 24) begin
                hi += int'(pwm_pin);
                ticks += int'(master_irq);
            end
        end
        cnt_en = 1'b1;
        chk(hi == 8, "R7 half-rate high clocks", hi, 8);
        chk(ticks == 2, "R7 half-rate ticks", ticks, 2);

        // R5 polarity locked while running, R6 stop, R8 output control
        do_reset();
        setup(3, 1);
        start_now();
        for (int c = 1; c <= 10; c++) begin
            if (c == 1) begin pol_wr = 1'b1; pol_wdata = 1'b1; end
            step();
            pol_wr = 1'b0;
            chk(pwm_pin == exp_level(c, 3, 1), "R5 polarity locked", int'(pwm_pin),
                int'(exp_level(c, 3, 1)));
        end
        held = pwm_pin;
        pc_hold = period_cnt;
        dc_hold = duty_cnt;
        stop_trig = 1'b1;
        step();
        stop_trig = 1'b0;
        chk(!master_run && !slave_run, "R6 flags", int'(master_run), 0);
        for (int c = 0; c < 3; c++) begin
            chk(period_cnt == pc_hold, "R6 period hold", int'(period_cnt), int'(pc_hold));
            chk(duty_cnt == dc_hold, "R6 duty hold", int'(duty_cnt), int'(dc_hold));
            chk(pwm_pin == held, "R6 level hold", int'(pwm_pin), int'(held));
            step();
        end
        pol_wr = 1'b1; pol_wdata = 1'b1;
        step();
        pol_wr = 1'b0;
        chk(pwm_pin == !held, "R8 polarity inverts", int'(pwm_pin), int'(!held));
        ctl_wr = 1'b1; oe_wdata = 1'b0; obit_wdata = 1'b1;
        step();
        chk(pwm_pin == 1'b1, "R8 software bit 1", int'(pwm_pin), 1);
        obit_wdata = 1'b0;
        step();
        ctl_wr = 1'b0;
        chk(pwm_pin == 1'b0, "R8 software bit 0", int'(pwm_pin), 0);
        start_trig = 1'b1; stop_trig = 1'b1;
        step();
        start_trig = 1'b0; stop_trig = 1'b0;
        chk(!master_run && !slave_run, "R6 stop wins", int'(master_run), 0);

        // R9 reset while running
        ctl_wr = 1'b1; oe_wdata = 1'b1; obit_wdata = 1'b1;
        step();
        ctl_wr = 1'b0;
        start_now();
        step();
        step();
        do_reset();
        chk(!master_run && !slave_run && period_cnt == 0 && duty_cnt == 0,
            "R9 running reset", int'(period_cnt), 0);
        chk(pwm_pin == 1'b0, "R9 output enable cleared", int'(pwm_pin), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule